// File: doc/BRIEF.md
# Divider Search Engine for a Programmable Clock Synthesizer

The block searches every pair of reference divider M and feedback divider N for the one that brings a synthesizer's output closest to a requested frequency. The request is a 16-bit target in units of 0.01 MHz. Before the search the target is clamped to a legal window. A power-of-two post-divide exponent K is then chosen by doubling the target until it reaches the oscillator's lower bound. The result is one packed 16-bit program word.

Each candidate frequency is modelled in fixed point with 8 fractional bits: a constant of 938356 (the reference crystal times 65536) is multiplied by N+8 and divided by 2^K * 256 * (M+2). The candidate's distance from the scaled target is compared with the best distance found so far. Control is plain: a one-cycle `start` launches a search when the engine is idle. `busy` covers the search and `done` marks the result. The result needs no back-pressure because `word` holds its value until the next result.

Top module: `pllsrch_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `word` is 0.
- R2: A start with target 0 gives `word` = 0x00E0 with `done` high in the cycle after the start; `busy` stays low.
- R3: A nonzero target below 8000 is treated as 8000, and a target above 15938 is treated as 15938.
- R4: The reference value is the clamped target times 256, divided by 100 and truncated. It is taken before any doubling.
- R5: K is the number of times the clamped target must be doubled to reach at least 64000.
- R6: Each candidate frequency is floor(938356*(N+8) / (2^K*256*(M+2))). M runs from 2 to 30 in the outer loop and N runs from 35 to 247 in the inner loop.
- R7: A candidate becomes the best only if its absolute distance from the reference is strictly smaller than the best so far, so on a tie the earliest pair in scan order (smaller M, then smaller N) is kept. The best distance starts at all ones.
- R8: `word` = (K<<6) + M + (N<<8): M in bits 4:0, bit 5 zero, K in bits 7:6, N in bits 15:8.
- R9: For a nonzero target, `busy` is high from the cycle after the start until the result. `done` is then high for exactly one cycle, with `busy` low, once the last pair is checked. `word` changes only when `done` rises.
- R10: A start while `busy` is high is ignored: the running search finishes with the result for its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; taken only while idle |
| target | input | 16 | Requested frequency in 0.01 MHz, sampled with `start` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| word | output | 16 | Packed K, M, N program word, held between results |

## Verification
The hardest behaviour to reach from the ports is the tie rule. Two pairs give the same distance only for particular targets, and the tie is then settled deep in the scan. The bench therefore runs a full software search for every target it applies and demands the exact word. A rule that kept the later pair on a tie would give a different M or N for such targets. A second start is injected in the middle of a running scan, with a different target, to show that the running search is not disturbed.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REF_GO,
    S_REF_WAIT,
    S_M_GO,
    S_M_WAIT,
    S_WARM,
    S_SCAN,
    S_FIN
  } pls_state_e;
endpackage

// File: rtl/pllsrch_prep.sv
module pllsrch_prep #(
  parameter int TGT_W = 16,
  parameter int F_MIN = 8000,
  parameter int F_MAX = 15938,
  parameter int LIMIT = 64000,
  parameter int K_MAX = 3,
  parameter int K_W   = 2
) (
  input  logic [TGT_W-1:0] tgt,
  output logic [TGT_W-1:0] clamped,
  output logic [K_W-1:0]   k
);
  localparam int SW = TGT_W + K_MAX;
  localparam logic [TGT_W-1:0] LO_V  = TGT_W'(F_MIN);
  localparam logic [TGT_W-1:0] HI_V  = TGT_W'(F_MAX);
  localparam logic [SW-1:0]    LIM_V = SW'(LIMIT);

  logic [SW-1:0] v;

  always_comb begin
    if (tgt < LO_V)      clamped = LO_V;
    else if (tgt > HI_V) clamped = HI_V;
    else                 clamped = tgt;
    v = {{K_MAX{1'b0}}, clamped};
    k = '0;
    for (int i = 0; i < K_MAX; i++) begin
      if (v < LIM_V) begin
        v = v << 1;
        k = k + K_W'(1);
      end
    end
  end
endmodule

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int DVD_W = 24,
  parameter int DSR_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quo,
  output logic [DSR_W-1:0] rem
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DSR_W-1:0] dsr_q;
  logic [DSR_W:0]   acc_q, shifted, acc_n;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q, fits;

  always_comb begin
    shifted = {acc_q[DSR_W-1:0], quo_q[DVD_W-1]};
    fits    = shifted >= {1'b0, dsr_q};
    acc_n   = fits ? shifted - {1'b0, dsr_q} : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_q  <= '0;
      acc_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        dsr_q <= divisor;
        acc_q <= '0;
        quo_q <= dividend;
        cnt_q <= CNT_W'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_n;
        quo_q <= {quo_q[DVD_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = acc_q[DSR_W-1:0];

  AST_DIV_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);                                                  // R6
  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc_q < {1'b0, dsr_q}));                             // R6
endmodule

// File: rtl/pllsrch_cmp.sv
module pllsrch_cmp #(
  parameter int Q_W = 24
) (
  input  logic [Q_W-1:0] ref_val,
  input  logic [Q_W-1:0] cand,
  input  logic [Q_W-1:0] best,
  output logic [Q_W-1:0] diff,
  output logic           better
);
  always_comb begin
    diff   = (ref_val > cand) ? ref_val - cand : cand - ref_val;
    better = diff < best;
  end
endmodule

// File: rtl/pllsrch_engine.sv
module pllsrch_engine
  import pllsrch_pkg::*;
#(
  parameter int TGT_W     = 16,
  parameter int WORD_W    = 16,
  parameter int F_MIN     = 8000,
  parameter int F_MAX     = 15938,
  parameter int LIMIT     = 64000,
  parameter int K_MAX     = 3,
  parameter int M_LO      = 2,
  parameter int M_HI      = 30,
  parameter int N_LO      = 35,
  parameter int N_HI      = 247,
  parameter int REF_NUM   = 938356,
  parameter int REF_DEN   = 100,
  parameter int FRAC_BITS = 8,
  parameter int ZERO_WORD = 16'h00E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TGT_W-1:0]  target,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int K_W   = $clog2(K_MAX + 1);
  localparam int M_W   = $clog2(M_HI + 1);
  localparam int N_W   = $clog2(N_HI + 1);
  localparam int D_W   = $clog2(M_HI + 3) + K_MAX + FRAC_BITS;
  localparam int Q_W   = TGT_W + FRAC_BITS;
  localparam int W_W   = $clog2(N_HI + 9);
  localparam logic [M_W-1:0]    M_LO_V = M_W'(M_LO);
  localparam logic [M_W-1:0]    M_HI_V = M_W'(M_HI);
  localparam logic [N_W-1:0]    N_LO_V = N_W'(N_LO);
  localparam logic [N_W-1:0]    N_HI_V = N_W'(N_HI);
  localparam logic [W_W-1:0]    W_LAST = W_W'(N_LO + 7);
  localparam logic [Q_W-1:0]    C_V    = Q_W'(REF_NUM);
  localparam logic [D_W-1:0]    DEN_V  = D_W'(REF_DEN);
  localparam logic [WORD_W-1:0] ZW_V   = WORD_W'(ZERO_WORD);

  pls_state_e st_q;
  logic [TGT_W-1:0]  clamp_c, clamp_q;
  logic [K_W-1:0]    k_c, k_q;
  logic [M_W-1:0]    m_q, bm_q;
  logic [N_W-1:0]    n_q, bn_q;
  logic [W_W-1:0]    w_q;
  logic [Q_W-1:0]    ref_q, best_q, q_q, qc_q, q_n, diff;
  logic [D_W-1:0]    r_q, rc_q, r_n, mp2, dsr_m;
  logic [D_W:0]      r_sum;
  logic              wrap, better;
  logic              done_q;
  logic [WORD_W-1:0] word_q;
  logic              div_go, div_done;
  logic [Q_W-1:0]    div_dvd, div_quo;
  logic [D_W-1:0]    div_dsr, div_rem;

  pllsrch_prep #(
    .TGT_W(TGT_W), .F_MIN(F_MIN), .F_MAX(F_MAX),
    .LIMIT(LIMIT), .K_MAX(K_MAX), .K_W(K_W)
  ) u_prep (
    .tgt(target), .clamped(clamp_c), .k(k_c)
  );

  // divisor for the current M: (M+2) * 2^K * 2^FRAC_BITS
  assign mp2   = {{(D_W-M_W){1'b0}}, m_q} + D_W'(2);
  assign dsr_m = (mp2 << k_q) << FRAC_BITS;

  assign div_go  = (st_q == S_REF_GO) || (st_q == S_M_GO);
  assign div_dvd = (st_q == S_REF_GO) ? {clamp_q, {FRAC_BITS{1'b0}}} : C_V;
  assign div_dsr = (st_q == S_REF_GO) ? DEN_V : dsr_m;

  pllsrch_div #(.DVD_W(Q_W), .DSR_W(D_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_dvd), .divisor(div_dsr),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  pllsrch_cmp #(.Q_W(Q_W)) u_cmp (
    .ref_val(ref_q), .cand(q_q), .best(best_q),
    .diff(diff), .better(better)
  );

  // step the running quotient/remainder of C*(N+8)/D by one N
  always_comb begin
    r_sum = {1'b0, r_q} + {1'b0, rc_q};
    wrap  = r_sum >= {1'b0, dsr_m};
    r_n   = wrap ? D_W'(r_sum - {1'b0, dsr_m}) : r_sum[D_W-1:0];
    q_n   = q_q + qc_q + Q_W'(wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      clamp_q <= '0;
      k_q     <= '0;
      m_q     <= '0;
      n_q     <= '0;
      w_q     <= '0;
      bm_q    <= '0;
      bn_q    <= '0;
      ref_q   <= '0;
      best_q  <= '1;
      q_q     <= '0;
      r_q     <= '0;
      qc_q    <= '0;
      rc_q    <= '0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          if (target == '0) begin
            word_q <= ZW_V;
            done_q <= 1'b1;
          end else begin
            clamp_q <= clamp_c;
            k_q     <= k_c;
            m_q     <= M_LO_V;
            best_q  <= '1;
            bm_q    <= '0;
            bn_q    <= '0;
            st_q    <= S_REF_GO;
          end
        end
        S_REF_GO:   st_q <= S_REF_WAIT;
        S_REF_WAIT: if (div_done) begin
          ref_q <= div_quo;
          st_q  <= S_M_GO;
        end
        S_M_GO:     st_q <= S_M_WAIT;
        S_M_WAIT: if (div_done) begin
          qc_q <= div_quo;
          rc_q <= div_rem;
          q_q  <= '0;
          r_q  <= '0;
          w_q  <= '0;
          st_q <= S_WARM;
        end
        S_WARM: begin
          q_q <= q_n;
          r_q <= r_n;
          w_q <= w_q + W_W'(1);
          if (w_q == W_LAST) begin
            n_q  <= N_LO_V;
            st_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (better) begin
            best_q <= diff;
            bm_q   <= m_q;
            bn_q   <= n_q;
          end
          q_q <= q_n;
          r_q <= r_n;
          if (n_q == N_HI_V) begin
            if (m_q == M_HI_V) begin
              st_q <= S_FIN;
            end else begin
              m_q  <= m_q + M_W'(1);
              st_q <= S_M_GO;
            end
          end else begin
            n_q <= n_q + N_W'(1);
          end
        end
        S_FIN: begin
          word_q <= (WORD_W'(bn_q) << 8) + (WORD_W'(k_q) << 6) + WORD_W'(bm_q);
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (st_q != S_IDLE);
  assign done = done_q;
  assign word = word_q;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                 // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);                                     // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(word));                                        // R9
  AST_WORD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && word != ZW_V) |-> (word[5] == 1'b0 &&
      word[4:0] >= 5'(M_LO) && word[4:0] <= 5'(M_HI) &&
      word[15:8] >= 8'(N_LO) && word[15:8] <= 8'(N_HI)));            // R8
  AST_BEST_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SCAN) |=> (best_q <= $past(best_q)));                 // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q != S_FIN) |=> busy);                               // R10
endmodule

// File: tb/pllsrch_engine_tb.sv
module pllsrch_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] target = '0;
  logic        busy, done;
  logic [15:0] word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllsrch_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .busy(busy), .done(done), .word(word)
  );

  function automatic logic [15:0] model(int t);
    longint rv, best, f, d, v;
    int k, bm, bn;
    if (t == 0) return 16'h00E0;
    if (t < 8000) t = 8000;
    if (t > 15938) t = 15938;
    rv = (longint'(t) * 256) / 100;
    v = t;
    k = 0;
    while (v < 64000) begin
      v = v * 2;
      k++;
    end
    best = 64'hFFFFFF;
    bm = 0;
    bn = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        f = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        d = (rv > f) ? rv - f : f - rv;
        if (d < best) begin
          best = d;
          bm = m;
          bn = n;
        end
      end
    end
    return 16'((k << 6) + bm + (bn << 8));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] t);
    @(negedge clk);
    start = 1'b1;
    target = t;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits on negedges until done; returns word, flags timeout as a failure
  task automatic wait_done(output logic [15:0] w);
    int n = 0;
    while (!done && n < WAIT_MAX) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R9 watchdog", n, WAIT_MAX);
    w = word;
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    chk(word === 16'h0, "R1 word", word, 0);
  endtask

  task automatic t_zero;
    pulse_start(16'd0);
    chk(done === 1'b1, "R2 done next cycle", done, 1);
    chk(busy === 1'b0, "R2 busy low", busy, 0);
    chk(word === 16'h00E0, "R2 word", word, 16'h00E0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single", done, 0);
  endtask

  task automatic t_search(input logic [15:0] t, input logic [15:0] exp, input string req);
    logic [15:0] w;
    pulse_start(t);
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    chk(done === 1'b0, "R9 no early done", done, 0);
    wait_done(w);
    chk(busy === 1'b0, "R9 busy low at done", busy, 0);
    chk(w === exp, req, w, exp);
    chk(w[5] === 1'b0 && w[7:6] === 2'd3, "R5 R8 K field", w[7:0], exp[7:0]);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single", done, 0);
  endtask

  task automatic t_clamp;
    t_search(16'd100,   model(8000),  "R3 low clamp");
    t_search(16'd65535, model(15938), "R3 high clamp");
  endtask

  task automatic t_ignore;
    logic [15:0] w;
    pulse_start(16'd9000);
    repeat (3000) @(negedge clk);
    chk(busy === 1'b1, "R10 busy mid scan", busy, 1);
    pulse_start(16'd14000);
    wait_done(w);
    chk(w === model(9000), "R10 start ignored", w, model(9000));
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 no second run", {busy, done}, 0);
  endtask

  task automatic t_hold;
    logic [15:0] w0;
    w0 = word;
    repeat (50) @(negedge clk);
    chk(word === w0, "R9 word held", word, w0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_search(16'd8000,  model(8000),  "R4 R6 R7 target 8000");
    t_search(16'd10000, model(10000), "R4 R6 R7 target 10000");
    t_search(16'd12345, model(12345), "R4 R6 R7 target 12345");
    t_search(16'd15938, model(15938), "R6 R7 R8 target 15938");
    t_clamp();
    t_ignore();
    t_hold();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 global watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule